// File: doc/BRIEF.md
# Externally Synchronised Input Capture

This block takes a snapshot of a 16-bit input word at a moment chosen by external equipment. The two sides use a ready/strobe handshake. The host issues an arm command, and the block raises a ready line towards the device. The device then gives a rising edge on its sync line. That edge freezes the input word into a capture register, drops ready and raises an interrupt to the host.

The host services the interrupt and reads the captured word. The read empties the register and raises ready again. Ready therefore tells the device whether the last word it delivered has been consumed.

The sync line is asynchronous to the block clock, so it passes through a two-stage synchroniser before edge detection. The data word is taken in the same cycle that the synchronised edge is seen. Both handshake latencies are fixed cycle counts. An elaboration-time check holds them under a parameterised limit (250 cycles, 1 µs at 250 MHz).

Top module: `ecap_top`

## Requirements
- R1: After reset the block is idle: readyOut is 0, irqOut is 0 and readData is 0.
- R2: An armCmd pulse while idle sets readyOut to 1 from the next clock edge.
- R3: A rising edge on syncIn while readyOut is 1 loads dataIn into the capture register, and readData then shows that word.
- R4: The same sync edge makes readyOut go to 0 and irqOut go to 1 exactly SYNC_STAGES+1 clock edges after syncIn rises (3 at default). This is never more than READY_LIMIT_CYC cycles.
- R5: A readCmd pulse while irqOut is 1 clears readData to 0, drops irqOut and sets readyOut to 1 on the next clock edge.
- R6: Sync edges while readyOut is 0 are ignored. When idle, readData stays 0 and no interrupt appears. When an interrupt is pending, the captured word is kept even if dataIn has changed.
- R7: armCmd while irqOut is 1 has no effect: readyOut stays 0, irqOut stays 1 and the word is kept.
- R8: A syncIn level that is already high when the block is armed causes no capture. Only a fresh low-to-high transition does.
- R9: readCmd while no interrupt is pending has no effect. Idle stays idle, and a ready block stays ready with readData at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| armCmd | input | 1 | One-cycle host command that enables the handshake |
| readCmd | input | 1 | One-cycle host read that consumes the captured word |
| syncIn | input | 1 | Asynchronous strobe from the external device |
| dataIn | input | DATA_W (16) | Input word sampled on the strobe |
| readyOut | output | 1 | Tells the device that a new word may be delivered |
| irqOut | output | 1 | Interrupt to the host: a captured word is waiting |
| readData | output | DATA_W (16) | Captured word, 0 when empty |

## Verification
Capture is tried with words that contain all ones, single high or low bits, alternating patterns and mixed values. A stuck or swapped data bit therefore shows up in readData. The ready-drop delay is counted edge by edge, which separates a correct two-flop synchroniser from a missing or extra stage.

Some rounds inject a second strobe with an inverted input word while the interrupt is pending, which would reveal a capture that is not gated. Other rounds re-arm before the read, which would reveal an arm command that overrides the pending state.

Directed sequences cover three more cases:
- a strobe held high across arming, which separates edge detection from level detection;
- reads issued while idle;
- reads issued while ready.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_READY    = 2'd1,
    ST_CAPTURED = 2'd2
  } capState_t;

  typedef struct packed {
    logic capture;
    logic clear;
  } ctrlStrobe_t;

endpackage

// File: rtl/ecap_dpath.sv
module ecap_dpath
  import ecap_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncIn,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrobe_t       strobe,
  output logic              syncEdge,
  output logic [DATA_W-1:0] capWord
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] syncPipe;
  logic [DATA_W-1:0] capReg;

  // synchroniser stages plus one delay stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[PIPE_W-2:0], syncIn};
  end

  assign syncEdge = syncPipe[SYNC_STAGES-1] & ~syncPipe[SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               capReg <= '0;
    else if (strobe.clear)   capReg <= '0;
    else if (strobe.capture) capReg <= dataIn;
  end

  assign capWord = capReg;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    syncEdge |=> !syncEdge); // R4
  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> capReg == $past(dataIn)); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> capReg == '0); // R5
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capture && !strobe.clear) |=> $stable(capReg)); // R6

endmodule

// File: rtl/ecap_ctrl.sv
module ecap_ctrl
  import ecap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        armCmd,
  input  logic        readCmd,
  input  logic        syncEdge,
  output ctrlStrobe_t strobe,
  output logic        readyOut,
  output logic        irqOut
);

  capState_t curState, nextState;

  always_comb begin
    nextState = curState;
    unique case (curState)
      ST_IDLE:     if (armCmd)   nextState = ST_READY;
      ST_READY:    if (syncEdge) nextState = ST_CAPTURED;
      ST_CAPTURED: if (readCmd)  nextState = ST_READY;
      default:                   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nextState;
  end

  always_comb begin
    strobe.capture = (curState == ST_READY) && syncEdge;
    strobe.clear   = (curState == ST_CAPTURED) && readCmd;
  end

  assign readyOut = (curState == ST_READY);
  assign irqOut   = (curState == ST_CAPTURED);

  AST_ARM_RAISES_READY: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut && !irqOut && armCmd) |=> readyOut); // R2
  AST_EDGE_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (readyOut && syncEdge) |=> (!readyOut && irqOut)); // R4
  AST_READ_REARMS: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && readCmd) |=> (readyOut && !irqOut)); // R5
  AST_ARM_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !readCmd) |=> irqOut); // R7
  AST_IDLE_SYNC_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!readyOut && !irqOut && !armCmd) |=> (!readyOut && !irqOut)); // R6
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({readyOut, irqOut})); // R4

endmodule

// File: rtl/ecap_top.sv
module ecap_top
  import ecap_pkg::*;
#(
  parameter int DATA_W          = 16,
  parameter int SYNC_STAGES     = 2,
  parameter int READY_LIMIT_CYC = 250
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armCmd,
  input  logic              readCmd,
  input  logic              syncIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              readyOut,
  output logic              irqOut,
  output logic [DATA_W-1:0] readData
);

  localparam int SYNC_TO_DROP_CYC = SYNC_STAGES + 1;
  localparam int READ_TO_READY_CYC = 1;

  generate
    if (SYNC_STAGES < 2) begin : g_badSync
      $error("ecap_top: SYNC_STAGES must be at least 2");
    end
    if (SYNC_TO_DROP_CYC > READY_LIMIT_CYC || READ_TO_READY_CYC > READY_LIMIT_CYC) begin : g_badLimit
      $error("ecap_top: handshake latency exceeds READY_LIMIT_CYC"); // R4
    end
  endgenerate

  ctrlStrobe_t strobe;
  logic        syncEdge;

  ecap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .armCmd   (armCmd),
    .readCmd  (readCmd),
    .syncEdge (syncEdge),
    .strobe   (strobe),
    .readyOut (readyOut),
    .irqOut   (irqOut)
  );

  ecap_dpath #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .syncIn   (syncIn),
    .dataIn   (dataIn),
    .strobe   (strobe),
    .syncEdge (syncEdge),
    .capWord  (readData)
  );

  AST_PENDING_NONZERO_OR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut && !$past(irqOut)) |-> readData == '0); // R1

endmodule

// File: tb/sim_ecap_top.sv
module sim_ecap_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        armCmd = 1'b0;
  logic        readCmd = 1'b0;
  logic        syncIn = 1'b0;
  logic [15:0] dataIn = 16'h0;
  logic        readyOut;
  logic        irqOut;
  logic [15:0] readData;

  int checks = 0;
  int fails  = 0;

  // row: {armWhilePending, noiseStrobe, word}
  localparam logic [17:0] VEC [0:5] = '{
    {1'b0, 1'b0, 16'hFFFF},
    {1'b0, 1'b1, 16'hA5A5},
    {1'b1, 1'b0, 16'h0001},
    {1'b1, 1'b1, 16'h8000},
    {1'b0, 1'b1, 16'h5A3C},
    {1'b1, 1'b0, 16'h1234}
  };

  ecap_top u0 (
    .clk      (clk),
    .rstN     (rstN),
    .armCmd   (armCmd),
    .readCmd  (readCmd),
    .syncIn   (syncIn),
    .dataIn   (dataIn),
    .readyOut (readyOut),
    .irqOut   (irqOut),
    .readData (readData)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulseArm();
    tick(); armCmd = 1'b1;
    tick(); armCmd = 1'b0;
  endtask

  task automatic pulseRead();
    tick(); readCmd = 1'b1;
    tick(); readCmd = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    @(negedge clk);
    check(readyOut == 1'b0, "R1", "ready after reset", 32'(readyOut), 0);
    check(irqOut == 1'b0,   "R1", "irq after reset",   32'(irqOut), 0);
    check(readData == 16'h0, "R1", "data after reset", 32'(readData), 0);
    tick(); rstN = 1'b1;
    repeat (2) tick();
    @(negedge clk);
    check(readyOut == 1'b0, "R1", "ready idle after release", 32'(readyOut), 0);

    // R9: read while idle
    pulseRead();
    repeat (2) tick();
    @(negedge clk);
    check(readyOut == 1'b0 && irqOut == 1'b0, "R9", "read while idle",
          {30'b0, readyOut, irqOut}, 0);

    // R6: strobe while idle
    dataIn = 16'hBEEF;
    tick(); syncIn = 1'b1;
    repeat (6) tick();
    syncIn = 1'b0;
    repeat (4) tick();
    @(negedge clk);
    check(irqOut == 1'b0 && readData == 16'h0, "R6", "strobe while idle",
          {15'b0, irqOut, readData}, 0);

    // R8: strobe already high at arm time
    syncIn = 1'b1;
    repeat (5) tick();
    pulseArm();
    @(negedge clk);
    check(readyOut == 1'b1, "R2", "ready after arm", 32'(readyOut), 1);
    repeat (8) tick();
    @(negedge clk);
    check(readyOut == 1'b1 && irqOut == 1'b0, "R8", "held strobe no capture",
          {30'b0, readyOut, irqOut}, 32'h2);
    check(readData == 16'h0, "R8", "held strobe data", 32'(readData), 0);
    tick(); syncIn = 1'b0;
    repeat (4) tick();

    for (int i = 0; i < 6; i++) begin
      logic [15:0] word;
      bit noise, armMid;
      int n;
      word   = VEC[i][15:0];
      noise  = VEC[i][16];
      armMid = VEC[i][17];
      dataIn = word;
      tick(); syncIn = 1'b1;
      n = 0;
      do begin
        @(posedge clk);
        n++;
        @(negedge clk);
      end while (readyOut && n < 10);
      check(n == 3, "R4", "ready drop latency", 32'(n), 3);
      check(irqOut == 1'b1, "R4", "irq after strobe", 32'(irqOut), 1);
      check(readData == word, "R3", "captured word", 32'(readData), 32'(word));
      tick(); syncIn = 1'b0;
      if (noise) begin
        dataIn = ~word;
        repeat (4) tick();
        syncIn = 1'b1;
        repeat (6) tick();
        syncIn = 1'b0;
        repeat (4) tick();
        @(negedge clk);
        check(readData == word && irqOut == 1'b1, "R6", "strobe while pending",
              32'(readData), 32'(word));
      end
      if (armMid) begin
        pulseArm();
        repeat (2) tick();
        @(negedge clk);
        check(readyOut == 1'b0 && irqOut == 1'b1 && readData == word, "R7",
              "arm while pending", {14'b0, readyOut, irqOut, readData},
              {16'h1, word});
      end
      pulseRead();
      @(negedge clk);
      check(readData == 16'h0, "R5", "data cleared by read", 32'(readData), 0);
      check(readyOut == 1'b1 && irqOut == 1'b0, "R5", "ready after read",
            {30'b0, readyOut, irqOut}, 32'h2);
      repeat (4) tick();
    end

    // R9: read while ready
    pulseRead();
    repeat (2) tick();
    @(negedge clk);
    check(readyOut == 1'b1 && irqOut == 1'b0 && readData == 16'h0, "R9",
          "read while ready", {14'b0, readyOut, irqOut, readData}, 32'h20000);

    summary();
    $finish;
  end

endmodule